// File: doc/BRIEF.md
# Static Memory Cycle Timing Generator

This block produces the strobe timing for one chip select that is set up for static memory. A requester hands it one transfer at a time: an address, a read/write flag, a transfer size and a beat count. The block then drives chip select, output enable, write enable and the four active-low byte-lane enables for as many bus clocks as the programmed timing requires. It raises a one-clock `beat_done` pulse on the final clock of every data beat.

A basic access is two clocks plus the programmed wait states. Asynchronous parts never get fewer than one wait state. An optional idle clock may follow a transfer. Bursts have a longer first beat and shorter later beats. A 32-bit transfer to a 16-bit or 8-bit port is split into ascending sub-accesses. In one port mode a beat ends when an external acknowledge arrives instead of when a wait counter expires.

The request side is a valid/ready stream. `req_ready` is high only while no transfer is in progress. A request is taken on any clock where `req_valid` and `req_ready` are both high. The requester must hold the request fields steady while `req_valid` is high and `req_ready` is low. The block samples the configuration inputs when it accepts a request and ignores later changes to them until the transfer ends. `beat_done` is a plain pulse that cannot be stalled.

Top module: `smt_timing_gen`

## Requirements
- R1: `req_ready` is high exactly when no transfer is active. A request is accepted on a clock with `req_valid && req_ready`, and `cs_n` goes low on the next clock and stays low until the last beat of the transfer has finished.
- R2: On a 32-bit port, an access that is not a later burst beat lasts 2 + `cfg_wait` clocks. `beat_done` is high on its final clock.
- R3: When `cfg_async` is 1 and `cfg_wait` is 0, the timing is the same as with `cfg_wait` = 1 (3 clocks). When `cfg_async` is 0 and `cfg_wait` is 0, an access lasts 2 clocks.
- R4: `oe_n` goes low only on reads and `we_n` only on writes, and never both at once. In a full-length access both stay high on the first clock; the active strobe is low from the second clock through the final clock.
- R5: With `cfg_idle` = 1, one extra clock with `cs_n` high follows the final beat before `req_ready` returns. With `cfg_idle` = 0, `req_ready` is high on the clock right after the final beat.
- R6: With `cfg_burst_en` = 1 on a 32-bit port (codes 00 and 11), every beat after the first lasts `cfg_bcyc` + 1 clocks (codes 00..11 give 1..4). `cs_n` stays low across beats, and the strobe stays active through the whole of each later beat.
- R7: The number of beats is 1 when `cfg_burst_en` = 0. Otherwise it is `req_beats` (where 0 counts as 1), limited to 2, 4, 8 or 16 for `cfg_blen` codes 00, 01, 10 and 11. Beat k uses address `req_addr` + k × transfer bytes.
- R8: `cfg_port` code 00 selects a 32-bit port, 01 a 16-bit port and 10 an 8-bit port. `req_size` code 00 is a byte, 01 a halfword, and 10 or 11 a word. A transfer wider than the port is split into port-wide sub-accesses at ascending addresses, each one of full length. `beat_done` fires only on the last sub-access, and `mem_addr` then shows that sub-access's address.
- R9: With `cfg_port` = 11 (a 32-bit port ended by acknowledge), an access ends on the first clock where `ack_n` is low, but never before its programmed length. With any other port code, `ack_n` has no effect on timing.
- R10: Byte lanes are assigned big-endian. Byte offset 0 within the port width maps to `be_n[3]` (data 31:24), and offsets 1, 2 and 3 map to `be_n[2]`, `be_n[1]` and `be_n[0]`. Narrow ports therefore use the upper lanes. All `be_n` bits are high while `cs_n` is high.
- R11: After reset, `cs_n`, `oe_n`, `we_n` and all `be_n` bits are high, `beat_done` is low and `req_ready` is high.
- R12: Exactly one `beat_done` pulse is produced for each beat, and only while `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Byte address of the first beat |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer size code (00 byte, 01 half, 10/11 word) |
| req_beats | input | BEATW | Requested beats (0 treated as 1) |
| cfg_wait | input | WAITW | Wait states added to the 2-clock base |
| cfg_async | input | 1 | 1 = asynchronous part, minimum one wait |
| cfg_idle | input | 1 | Add one idle clock after each transfer |
| cfg_burst_en | input | 1 | Allow multi-beat transfers |
| cfg_bcyc | input | 2 | Later-beat length code (1..4 clocks) |
| cfg_blen | input | 2 | Beat limit code (2, 4, 8, 16) |
| cfg_port | input | 2 | Port code (32, 16, 8 bit, 32 with acknowledge) |
| ack_n | input | 1 | External transfer acknowledge, active low |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| be_n | output | 4 | Byte-lane enables, active low |
| mem_addr | output | AW | Address of the current (sub-)access |
| beat_done | output | 1 | One-clock pulse on the final clock of a beat |

## Verification
The bench builds the block with AW = 12 and keeps the defaults WAITW = 4 and BEATW = 5. With these values every wait setting from 0 to 15 and the full 16-beat limit can be reached, while the addresses stay short enough to check them exactly. Each transfer's expected done-clock offsets, sub-access addresses and lane patterns are computed from the port, size, burst and wait settings. The tests cover both acknowledge arrival times in acknowledge mode, and acknowledge held low in a counter-timed mode.

// File: rtl/smt_pkg.sv
package smt_pkg;

  typedef enum logic [1:0] {
    PORT_32     = 2'b00,
    PORT_16     = 2'b01,
    PORT_8      = 2'b10,
    PORT_32_ACK = 2'b11
  } port_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'b00,
    SEQ_ACC  = 2'b01,
    SEQ_GAP  = 2'b10
  } seq_e;

  // log2 of the port width in bytes
  function automatic logic [1:0] port_log2(input logic [1:0] port);
    case (port)
      PORT_16: return 2'd1;
      PORT_8:  return 2'd0;
      default: return 2'd2;
    endcase
  endfunction

  // size codes 10 and 11 both mean a full word
  function automatic logic [1:0] size_log2(input logic [1:0] size);
    return (size == 2'b11) ? 2'b10 : size;
  endfunction

  // log2 of the number of sub-accesses per beat
  function automatic logic [1:0] split_log2(input logic [1:0] slog, input logic [1:0] plog);
    return (slog > plog) ? (slog - plog) : 2'd0;
  endfunction

endpackage

// File: rtl/smt_len.sv
module smt_len #(
  parameter int WAITW = 4,
  parameter int CNTW  = 5
) (
  input  logic [WAITW-1:0] wait_states,
  input  logic             async_mode,
  input  logic [1:0]       burst_clks,
  output logic [CNTW-1:0]  len_first,
  output logic [CNTW-1:0]  len_next
);
  logic [WAITW-1:0] eff_wait;

  // asynchronous parts always get at least one wait state
  always_comb begin
    eff_wait = wait_states;
    if (async_mode && (wait_states == '0)) eff_wait = WAITW'(1);
  end

  assign len_first = CNTW'(eff_wait) + CNTW'(2);
  assign len_next  = CNTW'(burst_clks) + CNTW'(1);
endmodule

// File: rtl/smt_lanes.sv
module smt_lanes (
  input  logic [1:0] addr_lo,
  input  logic [1:0] xfer_log2,
  input  logic [1:0] port_lg,
  output logic [3:0] lane_mask
);
  logic [1:0] piece_lg;
  logic [2:0] width;
  logic [1:0] off;
  logic [2:0] shift_amt;
  logic [3:0] ones;

  always_comb begin
    piece_lg  = (xfer_log2 < port_lg) ? xfer_log2 : port_lg;
    width     = 3'd1 << piece_lg;
    off       = addr_lo & 2'((3'd1 << port_lg) - 3'd1);
    ones      = 4'((5'd1 << width) - 5'd1);
    // offset 0 sits on the top lane
    shift_amt = 3'd4 - {1'b0, off} - width;
    lane_mask = ones << shift_amt;
  end
endmodule

// File: rtl/smt_seq.sv
module smt_seq
  import smt_pkg::*;
#(
  parameter int CNTW  = 5,
  parameter int BEATW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNTW-1:0]  len_first,
  input  logic [CNTW-1:0]  len_next,
  input  logic [1:0]       split_lg,
  input  logic [BEATW-1:0] beat_total,
  input  logic             short_ok,
  input  logic             ext_ack,
  input  logic             ack_n,
  input  logic             gap_en,
  output logic             ready,
  output logic             active,
  output logic             strobe,
  output logic             done,
  output logic [BEATW-1:0] beat_idx,
  output logic [1:0]       piece_idx
);
  seq_e            state;
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] cur_len;
  logic            short_beat;
  logic            at_min;
  logic            acc_end;
  logic            last_piece;
  logic            last_beat;

  always_comb begin
    short_beat = short_ok && (beat_idx != '0);
    cur_len    = short_beat ? len_next : len_first;
    at_min     = (cnt >= (cur_len - CNTW'(1)));
    acc_end    = at_min && (!ext_ack || !ack_n);
    last_piece = (piece_idx == 2'((3'd1 << split_lg) - 3'd1));
    last_beat  = (beat_idx == (beat_total - BEATW'(1)));
  end

  assign ready  = (state == SEQ_IDLE);
  assign active = (state == SEQ_ACC);
  assign strobe = active && (short_beat || (cnt != '0));
  assign done   = active && acc_end && last_piece;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      cnt       <= '0;
      beat_idx  <= '0;
      piece_idx <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state     <= SEQ_ACC;
            cnt       <= '0;
            beat_idx  <= '0;
            piece_idx <= '0;
          end
        end
        SEQ_ACC: begin
          if (acc_end) begin
            cnt <= '0;
            if (last_piece) begin
              piece_idx <= '0;
              if (last_beat) begin
                beat_idx <= '0;
                state    <= gap_en ? SEQ_GAP : SEQ_IDLE;
              end else begin
                beat_idx <= beat_idx + BEATW'(1);
              end
            end else begin
              piece_idx <= piece_idx + 2'd1;
            end
          end else if (cnt != '1) begin
            cnt <= cnt + CNTW'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smt_timing_gen.sv
module smt_timing_gen
  import smt_pkg::*;
#(
  parameter int AW    = 32,
  parameter int WAITW = 4,
  parameter int BEATW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [BEATW-1:0] req_beats,
  input  logic [WAITW-1:0] cfg_wait,
  input  logic             cfg_async,
  input  logic             cfg_idle,
  input  logic             cfg_burst_en,
  input  logic [1:0]       cfg_bcyc,
  input  logic [1:0]       cfg_blen,
  input  logic [1:0]       cfg_port,
  input  logic             ack_n,
  output logic             cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic [3:0]       be_n,
  output logic [AW-1:0]    mem_addr,
  output logic             beat_done
);
  localparam int CNTW = $clog2((1 << WAITW) + 3);

  logic             accept;
  logic [BEATW-1:0] beats_req, beats_cap, beats_eff;

  // transfer state captured at acceptance
  logic [AW-1:0]    base_q;
  logic             write_q;
  logic [1:0]       size_lg_q;
  logic [1:0]       port_lg_q;
  logic [1:0]       split_lg_q;
  logic [BEATW-1:0] beats_q;
  logic [WAITW-1:0] wait_q;
  logic             async_q, idle_q, ext_q, short_q;
  logic [1:0]       bcyc_q;

  logic [CNTW-1:0]  len_first, len_next;
  logic             active, strobe;
  logic [BEATW-1:0] beat_idx;
  logic [1:0]       piece_idx;
  logic [3:0]       lane_mask;
  logic [AW-1:0]    beat_off, piece_off;

  assign accept = req_valid && req_ready;

  always_comb begin
    beats_req = (req_beats == '0) ? BEATW'(1) : req_beats;
    beats_cap = BEATW'(2) << cfg_blen;
    if (!cfg_burst_en)              beats_eff = BEATW'(1);
    else if (beats_req < beats_cap) beats_eff = beats_req;
    else                            beats_eff = beats_cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      write_q    <= 1'b0;
      size_lg_q  <= '0;
      port_lg_q  <= 2'd2;
      split_lg_q <= '0;
      beats_q    <= BEATW'(1);
      wait_q     <= '0;
      async_q    <= 1'b0;
      idle_q     <= 1'b0;
      ext_q      <= 1'b0;
      short_q    <= 1'b0;
      bcyc_q     <= '0;
    end else if (accept) begin
      base_q     <= req_addr;
      write_q    <= req_write;
      size_lg_q  <= size_log2(req_size);
      port_lg_q  <= port_log2(cfg_port);
      split_lg_q <= split_log2(size_log2(req_size), port_log2(cfg_port));
      beats_q    <= beats_eff;
      wait_q     <= cfg_wait;
      async_q    <= cfg_async;
      idle_q     <= cfg_idle;
      ext_q      <= (cfg_port == PORT_32_ACK);
      short_q    <= (port_log2(cfg_port) == 2'd2);
      bcyc_q     <= cfg_bcyc;
    end
  end

  smt_len #(.WAITW(WAITW), .CNTW(CNTW)) u_len (
    .wait_states (wait_q),
    .async_mode  (async_q),
    .burst_clks  (bcyc_q),
    .len_first   (len_first),
    .len_next    (len_next)
  );

  smt_seq #(.CNTW(CNTW), .BEATW(BEATW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .len_first  (len_first),
    .len_next   (len_next),
    .split_lg   (split_lg_q),
    .beat_total (beats_q),
    .short_ok   (short_q),
    .ext_ack    (ext_q),
    .ack_n      (ack_n),
    .gap_en     (idle_q),
    .ready      (req_ready),
    .active     (active),
    .strobe     (strobe),
    .done       (beat_done),
    .beat_idx   (beat_idx),
    .piece_idx  (piece_idx)
  );

  always_comb begin
    beat_off  = AW'(beat_idx) << size_lg_q;
    piece_off = AW'(piece_idx) << port_lg_q;
    mem_addr  = base_q + beat_off + piece_off;
  end

  smt_lanes u_lanes (
    .addr_lo   (mem_addr[1:0]),
    .xfer_log2 (size_lg_q),
    .port_lg   (port_lg_q),
    .lane_mask (lane_mask)
  );

  assign cs_n = !active;
  assign oe_n = !(strobe && !write_q);
  assign we_n = !(strobe && write_q);
  assign be_n = active ? ~lane_mask : 4'hF;
endmodule

// File: rtl/smt_timing_chk.sv
module smt_timing_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       cs_n,
  input logic       oe_n,
  input logic       we_n,
  input logic [3:0] be_n,
  input logic       beat_done
);
  AST_READY_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n); // R1
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !cs_n); // R1
  AST_FIRST_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (oe_n && we_n)); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || we_n)); // R4
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || !we_n) |-> !cs_n); // R4
  AST_LANES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (be_n == 4'hF)); // R10
  AST_DONE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |-> !cs_n); // R12
endmodule

bind smt_timing_gen smt_timing_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cs_n      (cs_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .be_n      (be_n),
  .beat_done (beat_done)
);

// File: tb/sim_smt_timing_gen.sv
`timescale 1ns/1ps
module sim_smt_timing_gen;
  localparam int AW = 12;
  localparam int WAITW = 4;
  localparam int BEATW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic req_write = 1'b0;
  logic [1:0] req_size = 2'b10;
  logic [BEATW-1:0] req_beats = '0;
  logic [WAITW-1:0] cfg_wait = '0;
  logic cfg_async = 1'b0, cfg_idle = 1'b0, cfg_burst_en = 1'b0;
  logic [1:0] cfg_bcyc = '0, cfg_blen = '0, cfg_port = '0;
  logic ack_n = 1'b1;
  logic cs_n, oe_n, we_n, beat_done;
  logic [3:0] be_n;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int errors = 0;
  int exp_t[$];
  int exp_a[$];
  logic [3:0] exp_be[$];
  string exp_tag[$];
  int t_cs = 0;
  bit cs_prev = 0;
  bit bad_strobe = 0;
  bit cur_wr = 0;

  always #2.5 clk = ~clk;

  smt_timing_gen #(.AW(AW), .WAITW(WAITW), .BEATW(BEATW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
    .req_beats(req_beats), .cfg_wait(cfg_wait), .cfg_async(cfg_async),
    .cfg_idle(cfg_idle), .cfg_burst_en(cfg_burst_en), .cfg_bcyc(cfg_bcyc),
    .cfg_blen(cfg_blen), .cfg_port(cfg_port), .ack_n(ack_n), .cs_n(cs_n),
    .oe_n(oe_n), .we_n(we_n), .be_n(be_n), .mem_addr(mem_addr),
    .beat_done(beat_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: tracks clocks since chip select fell and scores each done pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n) begin
        t_cs = cs_prev ? t_cs + 1 : 0;
        if (t_cs == 0 && (!oe_n || !we_n)) bad_strobe = 1;
        if (cur_wr ? !oe_n : !we_n) bad_strobe = 1;
      end
      cs_prev = !cs_n;
      if (beat_done) begin
        if (exp_t.size() == 0) begin
          chk(0, "R12 unexpected done", 1, 0);
        end else begin
          int et, ea;
          logic [3:0] eb;
          string tg;
          et = exp_t.pop_front(); ea = exp_a.pop_front();
          eb = exp_be.pop_front(); tg = exp_tag.pop_front();
          chk(t_cs == et, {tg, " done clock"}, t_cs, et);
          chk(int'(mem_addr) == ea, {tg, " R7 R8 address"}, int'(mem_addr), ea);
          chk(be_n == eb, {tg, " R10 lanes"}, int'(be_n), int'(eb));
          chk(!bad_strobe && (cur_wr ? !we_n : !oe_n), {tg, " R4 strobe"},
              int'(bad_strobe), 0);
          bad_strobe = 0;
        end
      end
    end
  end

  function automatic logic [3:0] lanes(input int a, input int psz, input int pb);
    logic [3:0] m = 4'hF;
    for (int j = 0; j < psz; j++) m[3 - (a % pb) - j] = 1'b0;
    return m;
  endfunction

  task automatic send(input int addr, input bit wr, input int size, input int beats,
                      input int ack_at, input string tag);
    int pb, sb, psz, npc, l1, lb, nb, t, e, len, a;
    pb  = (cfg_port == 2'b01) ? 2 : (cfg_port == 2'b10) ? 1 : 4;
    sb  = 1 << ((size == 3) ? 2 : size);
    psz = (sb < pb) ? sb : pb;
    npc = (sb > pb) ? sb / pb : 1;
    l1  = 2 + ((cfg_async && cfg_wait == 0) ? 1 : int'(cfg_wait));
    lb  = int'(cfg_bcyc) + 1;
    nb  = (beats < 1) ? 1 : beats;
    if (nb > (2 << cfg_blen)) nb = 2 << cfg_blen;
    if (!cfg_burst_en) nb = 1;
    t = 0;
    for (int b = 0; b < nb; b++) begin
      for (int p = 0; p < npc; p++) begin
        len = (b > 0 && pb == 4) ? lb : l1;
        e = t + len - 1;
        if (cfg_port == 2'b11 && e < ack_at) e = ack_at;
        a = (addr + b * sb + p * pb) % (1 << AW);
        if (p == npc - 1) begin
          exp_t.push_back(e); exp_a.push_back(a);
          exp_be.push_back(lanes(a, psz, pb)); exp_tag.push_back(tag);
        end
        t = e + 1;
      end
    end
    do @(negedge clk); while (!req_ready);
    req_addr = AW'(addr); req_write = wr; req_size = 2'(size);
    req_beats = BEATW'(beats); cur_wr = wr; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (ack_at >= 0) begin
      repeat (ack_at) @(posedge clk);
      #1 ack_n = 1'b0;
    end
    while (exp_t.size() != 0) begin @(negedge clk); #0.1; end
    @(negedge clk);
    chk(req_ready == !cfg_idle, "R5 ready after final beat", int'(req_ready), int'(!cfg_idle));
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready returns", int'(req_ready), 1);
    ack_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=hung expected=complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(cs_n && oe_n && we_n && be_n == 4'hF && !beat_done && req_ready,
        "R11 reset outputs", {cs_n, oe_n, we_n, be_n, beat_done, req_ready},
        {3'b111, 4'hF, 1'b0, 1'b1});
    rst_n = 1'b1;
    // basic lengths
    cfg_wait = 0; send(12'h100, 0, 2, 1, -1, "R2 sync w0");
    cfg_wait = 5; send(12'h104, 1, 2, 1, -1, "R2 w5 write");
    cfg_wait = 15; send(12'h108, 0, 2, 1, -1, "R2 w15");
    cfg_async = 1; cfg_wait = 0; send(12'h10C, 0, 2, 1, -1, "R3 async w0");
    cfg_wait = 1; send(12'h110, 1, 2, 1, -1, "R3 async w1");
    cfg_async = 0; cfg_wait = 0; send(12'h114, 1, 2, 1, -1, "R3 sync w0");
    // lanes on the 32-bit port
    cfg_wait = 1;
    send(12'h201, 0, 0, 1, -1, "R10 byte off1");
    send(12'h203, 1, 0, 1, -1, "R10 byte off3");
    send(12'h202, 0, 1, 1, -1, "R10 half off2");
    // idle clock
    cfg_idle = 1; send(12'h300, 0, 2, 1, -1, "R5 idle");
    send(12'h304, 1, 1, 1, -1, "R5 idle write");
    cfg_idle = 0;
    // bursts
    cfg_burst_en = 1; cfg_bcyc = 2; cfg_blen = 1;
    send(12'h400, 0, 2, 6, -1, "R6 R7 burst capped");
    cfg_bcyc = 0; cfg_blen = 3; send(12'h440, 1, 2, 16, -1, "R6 R7 burst 16");
    send(12'h480, 0, 2, 0, -1, "R7 zero beats");
    cfg_burst_en = 0; send(12'h4C0, 0, 2, 4, -1, "R7 burst off");
    // narrow ports
    cfg_port = 2'b01; send(12'h040, 0, 2, 1, -1, "R8 16bit word");
    send(12'h046, 1, 1, 1, -1, "R8 16bit half");
    send(12'h045, 0, 0, 1, -1, "R8 R10 16bit byte");
    cfg_burst_en = 1; cfg_bcyc = 3; send(12'h050, 0, 1, 3, -1, "R6 R8 16bit burst");
    cfg_burst_en = 0;
    cfg_port = 2'b10; cfg_wait = 0; send(12'h060, 1, 2, 1, -1, "R8 8bit word");
    send(12'h066, 0, 1, 1, -1, "R8 8bit half");
    // external acknowledge
    cfg_port = 2'b11; cfg_wait = 2;
    send(12'h500, 0, 2, 1, 7, "R9 late ack");
    send(12'h504, 1, 2, 1, 0, "R9 early ack");
    cfg_burst_en = 1; cfg_bcyc = 1; cfg_blen = 0;
    send(12'h508, 0, 2, 2, 0, "R9 R6 ack burst");
    cfg_burst_en = 0;
    cfg_port = 2'b00; cfg_wait = 3; ack_n = 1'b0;
    send(12'h600, 0, 2, 1, -1, "R9 ack ignored");
    repeat (3) @(negedge clk);
    chk(exp_t.size() == 0, "R12 all beats done", exp_t.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule